// File: doc/BRIEF.md
# Double-Buffered DAC Update Scheduler

This block keeps the data and control registers of a 10-bit digital-to-analog converter and decides in which cycle a new code reaches the converter. Software writes a buffered word through a small byte-wide register bus: a low byte, a high byte and a control byte. The buffered word moves to the output latch only when the selected update event happens. The update event is one of three: a write to the high byte (on-demand), a pulse from a timer overflow, or an edge on an external trigger pin. This lets a new sample be prepared in advance and then applied as one step. A full-scale change never shows a half-written code, and samples paced by a timer come out without jitter from software.

The control byte also holds an enable bit and a 2-bit current-range field. The enable bit turns the converter on and switches the shared pin from GPIO use to the analog output. The converter itself, its bias generator and its range scaling are outside this block. The block only presents the latched code, the enable, the range and the pin-mux select.

Top module: `dac_update_sched`

## Requirements
- R1: On synchronous reset the control byte reads 0x70 (disabled, mode 3'b111, range 2'b00). The buffered word and the output latch are zero, and `dac_code`, `dac_en`, `pin_analog` and `dac_range` are all zero.
- R2: Bus address 0 is the low byte, 1 the high byte and 2 the control byte. High byte bits [7:0] hold word bits [9:2]. Low byte bits [7:6] hold word bits [1:0]. Other low-byte bits read as 0. Reads return the buffered word, not the latched code. `bus_rdata` shows the addressed register one cycle after the address is presented.
- R3: In on-demand mode (3'b111), a write to the low byte changes only the buffer. A write to the high byte commits {new high byte, buffered low bits} to the latch, and `dac_code` shows it one cycle after the write edge.
- R4: 8-bit use works: after the low byte is written once with 0x00, each high-byte write alone produces a code equal to the high byte shifted left by two.
- R5: In timer mode (3'b000), high-byte writes only fill the buffer. A `timer_ovf` pulse sampled at edge N latches the buffered word at N+1, and `dac_code` shows it after edge N+2.
- R6: Modes 3'b001, 3'b010 and 3'b011 update on a rising, falling or either edge of `ext_trig`. The pin passes through a two-flop synchronizer. A level change sampled at edge N appears on `dac_code` after edge N+4. Edges of the other direction cause no update.
- R7: The reserved modes 3'b100, 3'b101 and 3'b110 behave as on-demand mode. Timer pulses have no effect in them.
- R8: Control bit 7 is the enable. While it is 0, `dac_code` is 0 and `dac_en` and `pin_analog` are 0. All update events, including high-byte commits, are ignored, but the buffer and latch keep their values. Setting it again shows the retained latched code one cycle later.
- R9: Control bits [1:0] select the range (00, 01, 10). A write of 11 is stored as 10. Control bits [3:2] read as 0. `dac_range` follows the stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address: 0 low, 1 high, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data of the addressed register |
| timer_ovf | input | 1 | Single-cycle timer overflow pulse |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| dac_code | output | 10 | Latched converter code, zero while disabled |
| dac_en | output | 1 | Converter enable |
| dac_range | output | 2 | Output current range select |
| pin_analog | output | 1 | Pin-mux select: 1 routes the pin to the converter and disables its digital driver and pull-up |

## Verification
The assertions watch several rules on every cycle. The code must be zero in the cycle after the enable was low. The latch may change only after a commit or a detected event. No event may be taken while disabled. A low-byte write must never disturb the high bits of the buffer. The stored range must never hold 11. The synchronizer must not report two rising edges in a row. Only the bench scenarios can show the values: which word each mode commits, the exact latency of the timer and trigger paths, that edges of the wrong direction and reserved-mode timer pulses leave the code alone, and that the retained latch comes back after the block is enabled again.

// File: rtl/dac_sched_pkg.sv
package dac_sched_pkg;

  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;
  localparam int RNG_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

  // update-source codes; any code with bit 2 set behaves as on-demand
  localparam logic [2:0] MODE_TIMER  = 3'b000;
  localparam logic [2:0] MODE_RISE   = 3'b001;
  localparam logic [2:0] MODE_FALL   = 3'b010;
  localparam logic [2:0] MODE_EITHER = 3'b011;
  localparam logic [2:0] MODE_DEMAND = 3'b111;

  localparam logic [RNG_W-1:0] RANGE_TOP = 2'b10;

  typedef struct packed {
    logic             en;
    logic [2:0]       mode;
    logic [RNG_W-1:0] range;
  } ctrl_t;

  function automatic logic mode_on_demand(input logic [2:0] m);
    return m[2];
  endfunction

endpackage

// File: rtl/dac_sched_regs.sv
module dac_sched_regs
  import dac_sched_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BUS_W-1:0]      wdata,
  output logic [BUS_W-1:0]      rdata,
  output logic [DATA_W-1:0]     word_buf,
  output logic [DATA_W-1:0]     commit_word,
  output logic                  hi_wr,
  output ctrl_t                 ctrl
);

  localparam int LO_BITS = DATA_W - BUS_W;
  localparam int PAD     = BUS_W - LO_BITS;

  logic lo_wr;
  logic ctrl_wr;
  logic [BUS_W-1:0] rd_mux;

  assign lo_wr   = wr && (addr == ADDR_LO);
  assign hi_wr   = wr && (addr == ADDR_HI);
  assign ctrl_wr = wr && (addr == ADDR_CTRL);

  // word committed by an on-demand high-byte write: new high part, buffered low part
  assign commit_word = {wdata, word_buf[LO_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      word_buf <= '0;
    end else begin
      if (lo_wr) word_buf[LO_BITS-1:0]      <= wdata[BUS_W-1 -: LO_BITS];
      if (hi_wr) word_buf[DATA_W-1:LO_BITS] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl.en    <= 1'b0;
      ctrl.mode  <= MODE_DEMAND;
      ctrl.range <= '0;
    end else if (ctrl_wr) begin
      ctrl.en    <= wdata[7];
      ctrl.mode  <= wdata[6:4];
      ctrl.range <= (wdata[1:0] == 2'b11) ? RANGE_TOP : wdata[1:0];
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_LO:   rd_mux = {word_buf[LO_BITS-1:0], {PAD{1'b0}}};
      ADDR_HI:   rd_mux = word_buf[DATA_W-1:LO_BITS];
      ADDR_CTRL: rd_mux = {ctrl.en, ctrl.mode, 2'b00, ctrl.range};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  AST_RANGE_NOT_RESERVED: assert property (@(posedge clk) disable iff (rst)
    ctrl.range != 2'b11); // R9

  AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> $stable(word_buf[DATA_W-1:LO_BITS])); // R2

endmodule

// File: rtl/dac_sched_trig.sv
module dac_sched_trig #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= trig_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[i] <= 1'b0;
          else     sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise =  sync_q[STAGES-1] && !prev_q;
  assign fall = !sync_q[STAGES-1] &&  prev_q;

  AST_NO_DOUBLE_RISE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R6

endmodule

// File: rtl/dac_sched_out.sv
module dac_sched_out
  import dac_sched_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [2:0]        mode,
  input  logic              hi_wr,
  input  logic [DATA_W-1:0] commit_word,
  input  logic [DATA_W-1:0] word_buf,
  input  logic              timer_ovf,
  input  logic              rise,
  input  logic              fall,
  output logic [DATA_W-1:0] code
);

  logic              demand_upd;
  logic              ev_hit;
  logic              ev_q;
  logic [DATA_W-1:0] latch_q;

  always_comb begin
    demand_upd = en && mode_on_demand(mode) && hi_wr;
    ev_hit     = 1'b0;
    if (en && !mode_on_demand(mode)) begin
      unique case (mode[1:0])
        2'b00:   ev_hit = timer_ovf;
        2'b01:   ev_hit = rise;
        2'b10:   ev_hit = fall;
        default: ev_hit = rise || fall;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q    <= 1'b0;
      latch_q <= '0;
      code    <= '0;
    end else begin
      ev_q <= ev_hit;
      if (demand_upd)  latch_q <= commit_word;
      else if (ev_q)   latch_q <= word_buf;
      code <= en ? latch_q : '0;
    end
  end

  AST_OFF_FORCES_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (code == '0)); // R8

  AST_LATCH_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !$past(demand_upd || ev_q) |-> $stable(latch_q)); // R3

  AST_EVENT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ev_q |-> $past(en)); // R8

endmodule

// File: rtl/dac_update_sched.sv
module dac_update_sched
  import dac_sched_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              timer_ovf,
  input  logic              ext_trig,
  output logic [DATA_W-1:0] dac_code,
  output logic              dac_en,
  output logic [1:0]        dac_range,
  output logic              pin_analog
);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] word_buf;
  logic [DATA_W-1:0] commit_word;
  logic              hi_wr;
  logic              rise;
  logic              fall;

  dac_sched_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr          (bus_wr),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .rdata       (bus_rdata),
    .word_buf    (word_buf),
    .commit_word (commit_word),
    .hi_wr       (hi_wr),
    .ctrl        (ctrl)
  );

  dac_sched_trig #(.STAGES(SYNC_STAGES)) u_trig (
    .clk     (clk),
    .rst     (rst),
    .trig_in (ext_trig),
    .rise    (rise),
    .fall    (fall)
  );

  dac_sched_out #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .en          (ctrl.en),
    .mode        (ctrl.mode),
    .hi_wr       (hi_wr),
    .commit_word (commit_word),
    .word_buf    (word_buf),
    .timer_ovf   (timer_ovf),
    .rise        (rise),
    .fall        (fall),
    .code        (dac_code)
  );

  assign dac_en     = ctrl.en;
  assign pin_analog = ctrl.en;
  assign dac_range  = ctrl.range;

endmodule

// File: tb/dac_update_sched_test.sv
module dac_update_sched_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       timer_ovf = 1'b0;
  logic       ext_trig = 1'b0;
  logic [9:0] dac_code;
  logic       dac_en;
  logic [1:0] dac_range;
  logic       pin_analog;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dac_update_sched uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_ovf(timer_ovf),
    .ext_trig(ext_trig), .dac_code(dac_code), .dac_en(dac_en),
    .dac_range(dac_range), .pin_analog(pin_analog)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse_timer();
    timer_ovf = 1'b1;
    @(negedge clk);
    timer_ovf = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 code", 16'(dac_code), 16'h000);
    check("R1 en", 16'(dac_en), 16'h0);
    check("R1 pin", 16'(pin_analog), 16'h0);
    check("R1 range", 16'(dac_range), 16'h0);
    rd(2'd2, d); check("R1 ctrl", 16'(d), 16'h70);
    rd(2'd0, d); check("R1 lo", 16'(d), 16'h00);
    rd(2'd1, d); check("R1 hi", 16'(d), 16'h00);
  endtask

  task automatic t_demand();
    logic [7:0] d;
    wr(2'd2, 8'hF1);
    wr(2'd0, 8'hC0);
    idle(2);
    check("R3 low write alone", 16'(dac_code), 16'h000);
    wr(2'd1, 8'hA5);
    check("R3 before output edge", 16'(dac_code), 16'h000);
    idle(1);
    check("R3 commit", 16'(dac_code), 16'h297);
    check("R8 pin routed", 16'(pin_analog), 16'h1);
    check("R8 dac_en", 16'(dac_en), 16'h1);
    rd(2'd0, d); check("R2 lo read", 16'(d), 16'hC0);
    wr(2'd0, 8'h7F);
    rd(2'd0, d); check("R2 lo masked", 16'(d), 16'h40);
    rd(2'd1, d); check("R2 hi read", 16'(d), 16'hA5);
    check("R3 code holds after low write", 16'(dac_code), 16'h297);
  endtask

  task automatic t_8bit();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h10); idle(1);
    check("R4 sample 1", 16'(dac_code), 16'h040);
    wr(2'd1, 8'hFF); idle(1);
    check("R4 sample 2", 16'(dac_code), 16'h3FC);
  endtask

  task automatic t_timer();
    wr(2'd2, 8'h81);
    wr(2'd1, 8'h20);
    idle(3);
    check("R5 buffered only", 16'(dac_code), 16'h3FC);
    pulse_timer();
    idle(1);
    check("R5 not yet", 16'(dac_code), 16'h3FC);
    idle(1);
    check("R5 timer update", 16'(dac_code), 16'h080);
  endtask

  task automatic edge_expect(input logic lvl, input string req, input logic [9:0] old_v, input logic [9:0] new_v);
    ext_trig = lvl;
    idle(4);
    check(req, 16'(dac_code), 16'(old_v));
    idle(1);
    check(req, 16'(dac_code), 16'(new_v));
  endtask

  task automatic t_edges();
    wr(2'd2, 8'h91);
    wr(2'd1, 8'h30);
    edge_expect(1'b1, "R6 rising", 10'h080, 10'h0C0);
    wr(2'd1, 8'h31);
    ext_trig = 1'b0; idle(6);
    check("R6 falling ignored in rising mode", 16'(dac_code), 16'h0C0);
    wr(2'd2, 8'hA1);
    wr(2'd1, 8'h32);
    ext_trig = 1'b1; idle(6);
    check("R6 rising ignored in falling mode", 16'(dac_code), 16'h0C0);
    edge_expect(1'b0, "R6 falling", 10'h0C0, 10'h0C8);
    wr(2'd2, 8'hB1);
    wr(2'd1, 8'h33);
    edge_expect(1'b1, "R6 either rise", 10'h0C8, 10'h0CC);
    wr(2'd1, 8'h34);
    edge_expect(1'b0, "R6 either fall", 10'h0CC, 10'h0D0);
  endtask

  task automatic t_reserved();
    wr(2'd2, 8'hD1);
    wr(2'd1, 8'h44); idle(1);
    check("R7 reserved acts on-demand", 16'(dac_code), 16'h110);
    wr(2'd0, 8'hC0);
    pulse_timer(); idle(3);
    check("R7 timer ignored", 16'(dac_code), 16'h110);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_disable();
    logic [7:0] d;
    wr(2'd2, 8'h71); idle(1);
    check("R8 code forced zero", 16'(dac_code), 16'h000);
    check("R8 pin gpio", 16'(pin_analog), 16'h0);
    check("R8 en low", 16'(dac_en), 16'h0);
    wr(2'd1, 8'h55); idle(1);
    check("R8 commit ignored code", 16'(dac_code), 16'h000);
    wr(2'd2, 8'hF1);
    check("R8 not yet restored", 16'(dac_code), 16'h000);
    idle(1);
    check("R8 latch retained", 16'(dac_code), 16'h110);
    wr(2'd2, 8'h01);
    pulse_timer(); idle(2);
    wr(2'd2, 8'h81); idle(3);
    check("R8 timer ignored when off", 16'(dac_code), 16'h110);
    rd(2'd1, d); check("R8 buffer retained", 16'(d), 16'h55);
  endtask

  task automatic t_range();
    logic [7:0] d;
    wr(2'd2, 8'h83);
    check("R9 range saturates", 16'(dac_range), 16'h2);
    rd(2'd2, d); check("R9 ctrl read", 16'(d), 16'h82);
    wr(2'd2, 8'h8C);
    rd(2'd2, d); check("R9 bits 3:2 zero", 16'(d), 16'h80);
    check("R9 range 00", 16'(dac_range), 16'h0);
    wr(2'd2, 8'h81);
    check("R9 range 01", 16'(dac_range), 16'h1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_demand();
    t_8bit();
    t_timer();
    t_edges();
    t_reserved();
    t_disable();
    t_range();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule